// File: doc/BRIEF.md
# Atomic Swap Lock Memory

A small shared memory of 32-bit words, reachable from two requester ports, used as the backing store for spin locks. Each port can issue a plain load, a plain store or an atomic swap. A swap puts the requester's write value into the addressed word and hands back the word's previous contents. Both halves happen in one memory operation, so no access from the other port can fall between the read and the write.

A fixed-priority arbiter admits at most one request per cycle, and port 0 always wins. A port holds its request, with valid high, until ready is seen. The response comes one cycle after acceptance: a one-cycle done pulse plus read data on that port's lanes.

Lock software works like this. A word holding 0 is a free lock and a word holding 1 is a held lock. To acquire, a requester swaps in 1 and keeps repeating the swap until the returned value is 0. To release, the holder stores 0. A split load, add and store sequence from two requesters can lose an update, and the swap exists to close that gap.

Top module: `swap_lock_mem`

## Requirements
- R1: After reset every word reads 0, no done is high, and with no request pending no ready is high.
- R2: A load (op code 2'b00) returns the addressed word on the port's read data lane and leaves the word unchanged.
- R3: A store (op code 2'b01) writes the write value into the addressed word. Its response carries the word's previous contents.
- R4: A swap (op code 2'b10) writes the write value and returns the previous contents of the same word in one operation.
- R5: When both ports are valid in the same cycle, port 0 is accepted and port 1 is not. Port 1 is accepted in the first cycle in which port 0 is no longer valid.
- R6: At most one request is accepted per cycle, and ready is only high on a port whose valid is high.
- R7: Done rises on the accepting port exactly one cycle after acceptance, for one cycle only. The read data lane of the other port does not change.
- R8: If both ports swap 1 into a free lock word in the same cycle, exactly one of them reads back 0. After the holder stores 0, the other port's next swap reads back 0.
- R9: Op code 2'b11 behaves as a load: it returns the word and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | PORTS | Request valid, one bit per port |
| req_ready | output | PORTS | Request accepted this cycle, one bit per port |
| req_op | input | 2*PORTS | Operation code per port: 00 load, 01 store, 10 swap, 11 load |
| req_addr | input | AW*PORTS | Word address per port |
| req_wdata | input | WIDTH*PORTS | Write value per port (store and swap) |
| rsp_done | output | PORTS | One-cycle pulse, one cycle after acceptance |
| rsp_rdata | output | WIDTH*PORTS | Previous word contents per port, held between responses |

## Verification
The hardest case to reach is the race on a lock word. Both ports must present a swap of 1 to the same address in the very same cycle, and the loser must keep its request up while the winner is served. The bench drives both valids on the same falling edge. It then checks the ready pattern in that cycle and the value returned to each port in the following two cycles. A release by store, followed by a fresh swap from the former loser, completes the sequence. All sixteen words are swept with store, load and swap from alternating ports, and each returned value is compared against a value computed from the address.

// File: rtl/swaplock_pkg.sv
// Shared types for the atomic swap lock memory.
package swaplock_pkg;
    // Request operation codes; 2'b11 is decoded as a load.
    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_SWAP  = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;
endpackage

// File: rtl/swaplock_arbiter.sv
// Fixed-priority arbiter: the lowest-indexed valid port gets the grant.
// Assumes requesters hold valid until granted; the grant is combinational.
module swaplock_arbiter #(
    parameter int PORTS = 2
) (
    input  logic [PORTS-1:0] req_valid,
    output logic [PORTS-1:0] grant
);
    // Pick the first valid port, counting up from index 0.
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < PORTS; i++) begin
            if (req_valid[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/swaplock_select.sv
// Request multiplexer: forwards the granted port's op, address and data.
// Assumes the grant vector is one-hot or zero.
module swaplock_select
    import swaplock_pkg::*;
#(
    parameter int PORTS = 2,
    parameter int AW    = 4,
    parameter int WIDTH = 32
) (
    input  logic [PORTS-1:0]       grant,
    input  logic [2*PORTS-1:0]     req_op,
    input  logic [AW*PORTS-1:0]    req_addr,
    input  logic [WIDTH*PORTS-1:0] req_wdata,
    output logic                   sel_en,
    output op_e                    sel_op,
    output logic [AW-1:0]          sel_addr,
    output logic [WIDTH-1:0]       sel_wdata
);
    logic [1:0]       op_lane   [PORTS];
    logic [AW-1:0]    addr_lane [PORTS];
    logic [WIDTH-1:0] data_lane [PORTS];

    // Mask each lane with its grant bit.
    for (genvar g = 0; g < PORTS; g++) begin : g_lane
        assign op_lane[g]   = grant[g] ? req_op[2*g +: 2]          : '0;
        assign addr_lane[g] = grant[g] ? req_addr[AW*g +: AW]      : '0;
        assign data_lane[g] = grant[g] ? req_wdata[WIDTH*g +: WIDTH] : '0;
    end

    // OR the masked lanes together into the single memory request.
    always_comb begin
        logic [1:0] op_acc;
        op_acc    = '0;
        sel_addr  = '0;
        sel_wdata = '0;
        for (int i = 0; i < PORTS; i++) begin
            op_acc    = op_acc    | op_lane[i];
            sel_addr  = sel_addr  | addr_lane[i];
            sel_wdata = sel_wdata | data_lane[i];
        end
        sel_op = op_e'(op_acc);
        sel_en = |grant;
    end
endmodule

// File: rtl/swaplock_store.sv
// Word array with a single read-modify-write port. One operation per cycle:
// the old word is captured and the new value written on the same edge, so
// a swap cannot be split. Assumes addr < DEPTH.
module swaplock_store
    import swaplock_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    parameter int AW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  op_e              op,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata_q
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic             do_write;

    // Stores and swaps modify the word; loads and the reserved code do not.
    assign do_write = en && (op == OP_STORE || op == OP_SWAP);

    // Clear on reset; otherwise capture the old word and apply the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            rdata_q <= '0;
        end else begin
            if (en) rdata_q <= mem[addr];
            if (do_write) mem[addr] <= wdata;
        end
    end
endmodule

// File: rtl/swaplock_resp.sv
// Response router: raises done on the port accepted in the previous cycle
// and holds each port's last read value until its next response.
module swaplock_resp #(
    parameter int PORTS = 2,
    parameter int WIDTH = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PORTS-1:0]       accept,
    input  logic [WIDTH-1:0]       rdata,
    output logic [PORTS-1:0]       done,
    output logic [WIDTH*PORTS-1:0] lane_rdata
);
    logic [PORTS-1:0] done_q;
    logic [WIDTH-1:0] hold_q [PORTS];

    // Delay acceptance by one cycle to form the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= '0;
        else        done_q <= accept;
    end

    assign done = done_q;

    for (genvar g = 0; g < PORTS; g++) begin : g_port
        // Show fresh data on the responding port, the held value elsewhere.
        assign lane_rdata[WIDTH*g +: WIDTH] = done_q[g] ? rdata : hold_q[g];

        // Keep the value last shown on this port.
        always_ff @(posedge clk) begin
            if (!rst_n) hold_q[g] <= '0;
            else        hold_q[g] <= lane_rdata[WIDTH*g +: WIDTH];
        end
    end
endmodule

// File: rtl/swap_lock_mem.sv
// Two-port shared memory with load, store and atomic swap for spin locks.
// A fixed-priority arbiter admits one request per cycle (port 0 first);
// the response arrives one cycle after acceptance. Reset clears all words.
module swap_lock_mem
    import swaplock_pkg::*;
#(
    parameter int PORTS = 2,
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PORTS-1:0]       req_valid,
    output logic [PORTS-1:0]       req_ready,
    input  logic [2*PORTS-1:0]     req_op,
    input  logic [AW*PORTS-1:0]    req_addr,
    input  logic [WIDTH*PORTS-1:0] req_wdata,
    output logic [PORTS-1:0]       rsp_done,
    output logic [WIDTH*PORTS-1:0] rsp_rdata
);
    logic [PORTS-1:0] grant;
    logic             sel_en;
    op_e              sel_op;
    logic [AW-1:0]    sel_addr;
    logic [WIDTH-1:0] sel_wdata;
    logic [WIDTH-1:0] store_rdata;

    swaplock_arbiter #(.PORTS(PORTS)) u_arb (
        .req_valid (req_valid),
        .grant     (grant)
    );

    assign req_ready = grant;

    swaplock_select #(.PORTS(PORTS), .AW(AW), .WIDTH(WIDTH)) u_sel (
        .grant     (grant),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sel_en    (sel_en),
        .sel_op    (sel_op),
        .sel_addr  (sel_addr),
        .sel_wdata (sel_wdata)
    );

    swaplock_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (sel_en),
        .op      (sel_op),
        .addr    (sel_addr),
        .wdata   (sel_wdata),
        .rdata_q (store_rdata)
    );

    swaplock_resp #(.PORTS(PORTS), .WIDTH(WIDTH)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (grant),
        .rdata      (store_rdata),
        .done       (rsp_done),
        .lane_rdata (rsp_rdata)
    );
endmodule

// File: rtl/swaplock_checker.sv
// Port-level properties of the swap lock memory, bound to the top module.
module swaplock_checker #(
    parameter int PORTS = 2,
    parameter int DEPTH = 16,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [PORTS-1:0]       req_valid,
    input logic [PORTS-1:0]       req_ready,
    input logic [2*PORTS-1:0]     req_op,
    input logic [AW*PORTS-1:0]    req_addr,
    input logic [WIDTH*PORTS-1:0] req_wdata,
    input logic [PORTS-1:0]       rsp_done,
    input logic [WIDTH*PORTS-1:0] rsp_rdata
);
    a_r6_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_ready));

    a_r6_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready & ~req_valid) == '0);

    a_r5_port0_first: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |-> req_ready[0]);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_done));

    a_r7_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_valid & req_ready) == '0) |=> (rsp_done == '0));

    for (genvar g = 0; g < PORTS; g++) begin : g_chk
        a_r7_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid[g] && req_ready[g]) |=> rsp_done[g]);

        a_r7_lane_held: assert property (@(posedge clk) disable iff (!rst_n)
            !rsp_done[g] |=> (!rsp_done[g] -> $stable(rsp_rdata[WIDTH*g +: WIDTH])));
    end
endmodule

bind swap_lock_mem swaplock_checker #(
    .PORTS (PORTS),
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
) u_chk (.*);

// File: tb/swap_lock_mem_bench.sv
// Self-checking bench for swap_lock_mem: address sweep and lock race.
module swap_lock_mem_bench;
    localparam int PORTS = 2;
    localparam int DEPTH = 16;
    localparam int WIDTH = 32;
    localparam int AW    = 4;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [PORTS-1:0]       req_valid = '0;
    logic [PORTS-1:0]       req_ready;
    logic [2*PORTS-1:0]     req_op = '0;
    logic [AW*PORTS-1:0]    req_addr = '0;
    logic [WIDTH*PORTS-1:0] req_wdata = '0;
    logic [PORTS-1:0]       rsp_done;
    logic [WIDTH*PORTS-1:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    swap_lock_mem #(.PORTS(PORTS), .DEPTH(DEPTH), .WIDTH(WIDTH)) u_swap_lock_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int a);
        return (32'hA5000000 ^ (32'h01010101 * a)) + a;
    endfunction

    // Issue one request on port p and return its response.
    task automatic run_op(input int p, input logic [1:0] op, input int a,
                          input logic [31:0] d, output logic [31:0] rd);
        logic [31:0] other;
        @(negedge clk);
        req_valid[p] = 1'b1;
        req_op[2*p +: 2] = op;
        req_addr[AW*p +: AW] = AW'(a);
        req_wdata[WIDTH*p +: WIDTH] = d;
        #1;
        while (!req_ready[p]) begin
            @(negedge clk);
            #1;
        end
        check(req_ready == PORTS'(1 << p), "R6", 32'(req_ready), 32'(1 << p));
        other = rsp_rdata[WIDTH*(1-p) +: WIDTH];
        @(posedge clk);
        @(negedge clk);
        req_valid[p] = 1'b0;
        rd = rsp_rdata[WIDTH*p +: WIDTH];
        check(rsp_done == PORTS'(1 << p), "R7", 32'(rsp_done), 32'(1 << p));
        check(rsp_rdata[WIDTH*(1-p) +: WIDTH] == other, "R7 other lane",
              rsp_rdata[WIDTH*(1-p) +: WIDTH], other);
        @(negedge clk);
        check(rsp_done == '0, "R7 pulse", 32'(rsp_done), 0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: idle outputs after reset
        check(req_ready == '0, "R1 ready", 32'(req_ready), 0);
        check(rsp_done == '0, "R1 done", 32'(rsp_done), 0);

        // R1: every word reads zero after reset
        for (int a = 0; a < DEPTH; a++) begin
            run_op(a % 2, 2'b00, a, 32'hFFFF_FFFF, rd);
            check(rd == 0, "R1 reset word", rd, 0);
        end

        // R3, R2, R4 sweep over all addresses from alternating ports
        for (int a = 0; a < DEPTH; a++) begin
            run_op(a % 2, 2'b01, a, pattern(a), rd);
            check(rd == 0, "R3 store old", rd, 0);
        end
        for (int a = 0; a < DEPTH; a++) begin
            run_op(1 - (a % 2), 2'b00, a, 32'h0, rd);
            check(rd == pattern(a), "R2 load", rd, pattern(a));
            run_op(a % 2, 2'b00, a, 32'h0, rd);
            check(rd == pattern(a), "R2 load unchanged", rd, pattern(a));
        end
        for (int a = 0; a < DEPTH; a++) begin
            run_op(a % 2, 2'b10, a, ~pattern(a), rd);
            check(rd == pattern(a), "R4 swap old", rd, pattern(a));
            run_op(1 - (a % 2), 2'b00, a, 32'h0, rd);
            check(rd == ~pattern(a), "R4 swap new", rd, ~pattern(a));
        end

        // R9: reserved code reads but does not write
        run_op(0, 2'b11, 3, 32'h1234_5678, rd);
        check(rd == ~pattern(3), "R9 read", rd, ~pattern(3));
        run_op(1, 2'b00, 3, 32'h0, rd);
        check(rd == ~pattern(3), "R9 no write", rd, ~pattern(3));

        // R8 and R5: both ports race for a free lock word
        run_op(0, 2'b01, 5, 32'h0, rd);
        @(negedge clk);
        req_valid = 2'b11;
        req_op = {2'b10, 2'b10};
        req_addr = {4'd5, 4'd5};
        req_wdata = {32'h1, 32'h1};
        #1;
        check(req_ready == 2'b01, "R5 port0 wins", 32'(req_ready), 1);
        @(negedge clk);
        check(rsp_done == 2'b01, "R5 done port0", 32'(rsp_done), 1);
        check(rsp_rdata[31:0] == 0, "R8 winner sees free", rsp_rdata[31:0], 0);
        req_valid[0] = 1'b0;
        #1;
        check(req_ready == 2'b10, "R5 port1 next", 32'(req_ready), 2);
        @(negedge clk);
        req_valid[1] = 1'b0;
        check(rsp_done == 2'b10, "R5 done port1", 32'(rsp_done), 2);
        check(rsp_rdata[63:32] == 1, "R8 loser sees held", rsp_rdata[63:32], 1);
        run_op(1, 2'b10, 5, 32'h1, rd);
        check(rd == 1, "R8 still held", rd, 1);
        run_op(0, 2'b01, 5, 32'h0, rd);
        check(rd == 1, "R3 release old", rd, 1);
        run_op(1, 2'b10, 5, 32'h1, rd);
        check(rd == 0, "R8 acquire after release", rd, 0);

        // R6: no ready without valid
        @(negedge clk);
        check(req_ready == '0, "R6 idle", 32'(req_ready), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule